// File: doc/BRIEF.md
# Signed Divide Unit with HI/LO Result Registers

This block is the integer divide engine of a 64-bit core. The core offers it one instruction word per issue slot, together with the values already read for the two source register fields. When the word carries the signed-divide encoding and the unit is idle, the unit takes the low `WORD` bits of both values as two's-complement numbers. It divides the first (dividend) by the second (divisor) with a restoring shift-subtract loop on magnitudes, then applies sign correction.

On completion the quotient goes into the LO register and the remainder into the HI register. Each value is sign-extended from bit `WORD-1` to the full `XLEN` width. The unit never traps. A zero divisor and the most-negative-by-minus-one case both give fixed, defined results. Both registers are always visible on read ports.

The unit also watches the issue stream for HI/LO reads. A divide that is accepted while such a read sits in either of the two previous issue slots raises a one-cycle hazard flag.

Top module: `sdiv_hilo`

## Requirements
- R1: A word is accepted as a divide only when bits 31..26 are 000000, bits 15..6 are all zero and bits 5..0 are 011010, and it is issued (`iss_vld_i` high) while `busy_o` is low. Any other word leaves `busy_o` low and HI/LO unchanged.
- R2: For a non-zero divisor, the quotient truncates toward zero and is written to LO, and the remainder is written to HI. The remainder is zero or has the dividend's sign, and quotient × divisor + remainder equals the dividend modulo 2^WORD.
- R3: Only bits WORD-1..0 of each operand value are used. Bits XLEN-1..WORD of HI and of LO always equal bit WORD-1 of the same register.
- R4: A zero divisor gives a LO of all ones and a HI equal to the sign-extended dividend, with no trap.
- R5: The most negative dividend divided by −1 gives a LO equal to the most negative value (sign-extended) and a HI of 0, with no trap.
- R6: `busy_o` rises on the clock edge that accepts a divide and stays high for exactly WORD+2 cycles. On the edge where it falls, HI and LO take the new results and `done_o` is high for that one cycle.
- R7: A divide issued while `busy_o` is high is ignored: the running result is unaffected and no second operation follows.
- R8: After reset, HI, LO, `busy_o`, `done_o` and `hazard_o` are zero. HI and LO change only in a cycle where `done_o` is high.
- R9: Every cycle with `iss_vld_i` high is one issue slot. If either of the two slots before an accepted divide had `rd_hi_i` or `rd_lo_i` high, `hazard_o` is high for the one cycle after the accepting edge. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_vld_i | input | 1 | An instruction occupies this issue slot |
| instr_i | input | 32 | Instruction word of the slot |
| rs_val_i | input | XLEN | Dividend value (source field at bits 25..21) |
| rt_val_i | input | XLEN | Divisor value (source field at bits 20..16) |
| rd_hi_i | input | 1 | The slot's instruction reads HI |
| rd_lo_i | input | 1 | The slot's instruction reads LO |
| busy_o | output | 1 | Divide in progress |
| done_o | output | 1 | HI/LO written this cycle |
| hazard_o | output | 1 | Accepted divide had a HI/LO read too close before it |
| hi_o | output | XLEN | HI register (remainder) |
| lo_o | output | XLEN | LO register (quotient) |

## Verification
The bench builds the unit with WORD=6 and XLEN=12. This makes all 4096 dividend/divisor pairs reachable in one run, including the zero divisor and the −32 ÷ −1 corner. Non-sign-extended junk in operand bits 11..6 and six bits of sign extension on every result bring the width rules of R3 into each comparison. Directed sequences then cover rejected encodings, a start during busy, and the three spacings of a HI/LO read ahead of a divide.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

   localparam logic [5:0] OPC_SPECIAL = 6'b000000;
   localparam logic [5:0] FN_SDIV     = 6'b011010;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_ITER  = 2'd2,
      ST_FIN   = 2'd3
   } sdiv_st_e;

   function automatic logic is_sdiv(input logic [31:0] iw);
      return (iw[31:26] == OPC_SPECIAL) && (iw[15:6] == 10'd0) && (iw[5:0] == FN_SDIV);
   endfunction

endpackage

// File: rtl/sdiv_decode.sv
module sdiv_decode (
   input  logic [31:0] instr_i,
   output logic        is_div_o
);
   import sdiv_pkg::*;

   // register selector fields are resolved upstream into operand values
   logic unused_sel;
   assign unused_sel = ^instr_i[25:16];

   assign is_div_o = is_sdiv(instr_i);
endmodule

// File: rtl/sdiv_hazard.sv
module sdiv_hazard #(
   parameter int GAP = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slot_i,
   input  logic rd_i,
   input  logic acc_i,
   output logic hazard_o
);
   logic [GAP-1:0] hist_q;

   generate
      if (GAP < 1) begin : g_bad_gap
         $error("sdiv_hazard: GAP must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q   <= '0;
         hazard_o <= 1'b0;
      end else begin
         hazard_o <= acc_i && (|hist_q);
         if (slot_i) begin
            if (GAP > 1) hist_q <= {hist_q[GAP-2:0], rd_i};
            else         hist_q <= rd_i;
         end
      end
   end
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
   parameter int WORD = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go_i,
   input  logic [WORD-1:0] a_i,
   input  logic [WORD-1:0] b_i,
   output logic            busy_o,
   output logic            fin_o,
   output logic [WORD-1:0] q_o,
   output logic [WORD-1:0] r_o
);
   import sdiv_pkg::*;

   localparam int CW = (WORD > 2) ? $clog2(WORD) : 1;
   localparam logic [CW-1:0] LAST = CW'(WORD - 1);

   sdiv_st_e        st_q;
   logic [WORD-1:0] a_q, b_q, rem_q, quo_q, dm_q;
   logic [CW-1:0]   cnt_q;
   logic            negq_q, negr_q, zero_q;

   // one restoring step
   logic [WORD:0]   shifted, trial;
   logic            qbit;
   logic [WORD-1:0] rem_nx;

   always_comb begin
      shifted = {rem_q, quo_q[WORD-1]};
      trial   = shifted - {1'b0, dm_q};
      qbit    = ~trial[WORD];
      rem_nx  = qbit ? trial[WORD-1:0] : shifted[WORD-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         a_q    <= '0;
         b_q    <= '0;
         rem_q  <= '0;
         quo_q  <= '0;
         dm_q   <= '0;
         cnt_q  <= '0;
         negq_q <= 1'b0;
         negr_q <= 1'b0;
         zero_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (go_i) begin
               a_q  <= a_i;
               b_q  <= b_i;
               st_q <= ST_SETUP;
            end
            ST_SETUP: begin
               quo_q  <= a_q[WORD-1] ? (~a_q + WORD'(1)) : a_q;
               dm_q   <= b_q[WORD-1] ? (~b_q + WORD'(1)) : b_q;
               rem_q  <= '0;
               cnt_q  <= '0;
               negq_q <= a_q[WORD-1] ^ b_q[WORD-1];
               negr_q <= a_q[WORD-1];
               zero_q <= (b_q == '0);
               st_q   <= ST_ITER;
            end
            ST_ITER: begin
               rem_q <= rem_nx;
               quo_q <= {quo_q[WORD-2:0], qbit};
               if (cnt_q == LAST) st_q <= ST_FIN;
               else               cnt_q <= cnt_q + CW'(1);
            end
            ST_FIN: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (st_q != ST_IDLE);
   assign fin_o  = (st_q == ST_FIN);

   always_comb begin
      if (zero_q) begin
         q_o = '1;
         r_o = a_q;
      end else begin
         q_o = negq_q ? (~quo_q + WORD'(1)) : quo_q;
         r_o = negr_q ? (~rem_q + WORD'(1)) : rem_q;
      end
   end
endmodule

// File: rtl/sdiv_hilo.sv
module sdiv_hilo #(
   parameter int XLEN = 64,
   parameter int WORD = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            iss_vld_i,
   input  logic [31:0]     instr_i,
   input  logic [XLEN-1:0] rs_val_i,
   input  logic [XLEN-1:0] rt_val_i,
   input  logic            rd_hi_i,
   input  logic            rd_lo_i,
   output logic            busy_o,
   output logic            done_o,
   output logic            hazard_o,
   output logic [XLEN-1:0] hi_o,
   output logic [XLEN-1:0] lo_o
);
   generate
      if (WORD < 2 || XLEN < WORD) begin : g_bad_cfg
         $error("sdiv_hilo: need WORD >= 2 and XLEN >= WORD");
      end
   endgenerate

   logic            is_div, accept, fin;
   logic [WORD-1:0] q_w, r_w;
   logic [XLEN-1:0] q_x, r_x;

   sdiv_decode i_dec (.instr_i(instr_i), .is_div_o(is_div));

   assign accept = iss_vld_i && is_div && !busy_o;

   sdiv_core #(.WORD(WORD)) i_core (
      .clk(clk), .rst_n(rst_n), .go_i(accept),
      .a_i(rs_val_i[WORD-1:0]), .b_i(rt_val_i[WORD-1:0]),
      .busy_o(busy_o), .fin_o(fin), .q_o(q_w), .r_o(r_w)
   );

   sdiv_hazard #(.GAP(2)) i_haz (
      .clk(clk), .rst_n(rst_n), .slot_i(iss_vld_i),
      .rd_i(rd_hi_i | rd_lo_i), .acc_i(accept), .hazard_o(hazard_o)
   );

   generate
      if (XLEN > WORD) begin : g_sext
         logic unused_upper;
         assign unused_upper = ^{rs_val_i[XLEN-1:WORD], rt_val_i[XLEN-1:WORD]};
         assign q_x = {{(XLEN-WORD){q_w[WORD-1]}}, q_w};
         assign r_x = {{(XLEN-WORD){r_w[WORD-1]}}, r_w};
      end else begin : g_flat
         assign q_x = q_w;
         assign r_x = r_w;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_o   <= '0;
         lo_o   <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= fin;
         if (fin) begin
            lo_o <= q_x;
            hi_o <= r_x;
         end
      end
   end
endmodule

// File: rtl/sdiv_hilo_chk.sv
module sdiv_hilo_chk #(
   parameter int XLEN = 64,
   parameter int WORD = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            iss_vld_i,
   input logic [5:0]      opc,
   input logic [9:0]      mid,
   input logic [5:0]      fn,
   input logic [WORD-1:0] a_lo,
   input logic [WORD-1:0] b_lo,
   input logic            busy_o,
   input logic            done_o,
   input logic            hazard_o,
   input logic [XLEN-1:0] hi_o,
   input logic [XLEN-1:0] lo_o
);
   localparam int BW = $clog2(WORD + 3);

   logic            acc;
   logic [WORD-1:0] ca_q, cb_q, recon;
   logic [BW-1:0]   bcnt_q;

   assign acc   = iss_vld_i && !busy_o && opc == 6'd0 && mid == 10'd0 && fn == 6'b011010;
   assign recon = lo_o[WORD-1:0] * cb_q + hi_o[WORD-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ca_q   <= '0;
         cb_q   <= '0;
         bcnt_q <= '0;
      end else if (acc) begin
         ca_q   <= a_lo;
         cb_q   <= b_lo;
         bcnt_q <= '0;
      end else if (busy_o) begin
         bcnt_q <= bcnt_q + BW'(1);
      end
   end

   AST_HILO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_o != $past(hi_o) || lo_o != $past(lo_o)) |-> done_o);                    // R8
   AST_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && cb_q != '0) |-> recon == ca_q);                                     // R2
   AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && cb_q != '0 && hi_o[WORD-1:0] != '0) |-> hi_o[WORD-1] == ca_q[WORD-1]); // R2
   AST_ZERO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && cb_q == '0) |-> (lo_o[WORD-1:0] == '1 && hi_o[WORD-1:0] == ca_q));  // R4
   AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> bcnt_q == BW'(WORD + 2));                                           // R6
   AST_DONE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));                                        // R6
   AST_HAZ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      hazard_o |-> $past(acc));                                                      // R9

   generate
      if (XLEN > WORD) begin : g_ext_chk
         AST_SIGN_EXT_HI: assert property (@(posedge clk) disable iff (!rst_n)
            hi_o[XLEN-1:WORD] == {(XLEN-WORD){hi_o[WORD-1]}});                       // R3
         AST_SIGN_EXT_LO: assert property (@(posedge clk) disable iff (!rst_n)
            lo_o[XLEN-1:WORD] == {(XLEN-WORD){lo_o[WORD-1]}});                       // R3
      end
   endgenerate
endmodule

bind sdiv_hilo sdiv_hilo_chk #(.XLEN(XLEN), .WORD(WORD)) i_chk (
   .clk(clk), .rst_n(rst_n), .iss_vld_i(iss_vld_i),
   .opc(instr_i[31:26]), .mid(instr_i[15:6]), .fn(instr_i[5:0]),
   .a_lo(rs_val_i[WORD-1:0]), .b_lo(rt_val_i[WORD-1:0]),
   .busy_o(busy_o), .done_o(done_o), .hazard_o(hazard_o),
   .hi_o(hi_o), .lo_o(lo_o)
);

// File: tb/test_sdiv_hilo.sv
module test_sdiv_hilo;
   localparam int W = 6;
   localparam int X = 12;
   localparam logic [31:0] DIVW = {6'b000000, 5'd4, 5'd5, 10'd0, 6'b011010};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         iss_vld = 1'b0;
   logic [31:0]  instr = '0;
   logic [X-1:0] rs_val = '0, rt_val = '0;
   logic         rd_hi = 1'b0, rd_lo = 1'b0;
   logic         busy, done, hazard;
   logic [X-1:0] hi, lo;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;   // 50 MHz

   sdiv_hilo #(.XLEN(X), .WORD(W)) i_sdiv_hilo (
      .clk(clk), .rst_n(rst_n), .iss_vld_i(iss_vld), .instr_i(instr),
      .rs_val_i(rs_val), .rt_val_i(rt_val), .rd_hi_i(rd_hi), .rd_lo_i(rd_lo),
      .busy_o(busy), .done_o(done), .hazard_o(hazard), .hi_o(hi), .lo_o(lo)
   );

   task automatic chk(input bit ok, input string req, input logic [X-1:0] act, input logic [X-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic expect_div(input logic [W-1:0] a6, input logic [W-1:0] b6,
                             output logic [X-1:0] q, output logic [X-1:0] r);
      int sa, sb, qi, ri;
      sa = int'($signed(a6));
      sb = int'($signed(b6));
      if (sb == 0) begin
         qi = -1; ri = sa;
      end else if (sa == -(1 << (W-1)) && sb == -1) begin
         qi = sa; ri = 0;
      end else begin
         qi = sa / sb; ri = sa % sb;
      end
      q = X'(qi);
      r = X'(ri);
   endtask

   // drives one issue slot at a negedge; returns at the negedge after it was clocked
   task automatic issue(input logic [31:0] iw, input logic [X-1:0] a, input logic [X-1:0] b,
                        input logic rh, input logic rl);
      @(negedge clk);
      iss_vld = 1'b1; instr = iw; rs_val = a; rt_val = b; rd_hi = rh; rd_lo = rl;
      @(negedge clk);
      iss_vld = 1'b0; instr = '0; rd_hi = 1'b0; rd_lo = 1'b0;
   endtask

   task automatic run_div(input logic [W-1:0] a6, input logic [W-1:0] b6,
                          input logic [X-W-1:0] ja, input logic [X-W-1:0] jb,
                          input string req, output logic haz);
      logic [X-1:0] eq, er;
      expect_div(a6, b6, eq, er);
      issue(DIVW, {ja, a6}, {jb, b6}, 1'b0, 1'b0);
      haz = hazard;
      chk(busy === 1'b1, "R6 busy after accept", X'(busy), X'(1));
      repeat (W + 1) @(negedge clk);
      chk(busy === 1'b1 && done === 1'b0, "R6 still busy before last edge", X'({busy, done}), X'(2));
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b1, "R6 done as busy falls", X'({busy, done}), X'(1));
      chk(lo === eq, {req, " LO quotient"}, lo, eq);
      chk(hi === er, {req, " HI remainder"}, hi, er);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic h;
      logic [X-1:0] ph, pl;
      repeat (3) @(negedge clk);
      // R8 reset state
      chk(hi === '0 && lo === '0, "R8 reset HI/LO", hi | lo, '0);
      chk(busy === 1'b0 && done === 1'b0 && hazard === 1'b0, "R8 reset flags",
          X'({busy, done, hazard}), '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(hi === '0 && lo === '0, "R8 idle hold after reset", hi | lo, '0);

      // exhaustive sweep, junk in upper operand bits (R3)
      for (int a = 0; a < (1 << W); a++) begin
         for (int b = 0; b < (1 << W); b++) begin
            string req;
            if (b == 0) req = "R4";
            else if (a == (1 << (W-1)) && b == (1 << W) - 1) req = "R5";
            else req = "R2";
            run_div(W'(a), W'(b), (X-W)'(a * 5 + 3), (X-W)'(b * 11 + 1), req, h);
         end
      end

      // R3 dedicated: negative quotient, upper operand bits not sign extension
      run_div(6'd9, 6'h3e, 6'b010101, 6'b000001, "R3", h);
      chk(lo[X-1:W] === '1, "R3 LO upper bits", lo, 12'hffc);

      // R1 rejected encodings
      ph = hi; pl = lo;
      issue(DIVW | 32'h0400_0000, 12'd20, 12'd3, 1'b0, 1'b0);
      chk(busy === 1'b0, "R1 opcode bit set ignored", X'(busy), '0);
      issue(DIVW | 32'h0000_0040, 12'd20, 12'd3, 1'b0, 1'b0);
      chk(busy === 1'b0, "R1 bit 6 set ignored", X'(busy), '0);
      issue({DIVW[31:6], 6'b011011}, 12'd20, 12'd3, 1'b0, 1'b0);
      chk(busy === 1'b0, "R1 other function ignored", X'(busy), '0);
      repeat (W + 4) @(negedge clk);
      chk(hi === ph && lo === pl, "R1 HI/LO unchanged", {hi[5:0], lo[5:0]}, {ph[5:0], pl[5:0]});

      // R7 start while busy ignored: 20 / 3 then -7 / 2 mid-flight
      issue(DIVW, 12'd20, 12'd3, 1'b0, 1'b0);
      repeat (2) @(negedge clk);
      issue(DIVW, 12'hff9, 12'd2, 1'b0, 1'b0);
      begin
         int n = 0;
         while (done !== 1'b1 && n < 40) begin @(negedge clk); n++; end
      end
      chk(lo === 12'd6 && hi === 12'd2, "R7 first result kept", {lo[5:0], hi[5:0]}, {6'd6, 6'd2});
      @(negedge clk);
      chk(busy === 1'b0, "R7 no queued divide", X'(busy), '0);

      // R9 hazard spacing
      issue(32'h0, '0, '0, 1'b0, 1'b1);
      run_div(6'd7, 6'd2, '0, '0, "R2", h);
      chk(h === 1'b1, "R9 read one slot before", X'(h), X'(1));
      issue(32'h0, '0, '0, 1'b1, 1'b0);
      issue(32'h0, '0, '0, 1'b0, 1'b0);
      run_div(6'd7, 6'd2, '0, '0, "R2", h);
      chk(h === 1'b1, "R9 read two slots before", X'(h), X'(1));
      issue(32'h0, '0, '0, 1'b1, 1'b0);
      issue(32'h0, '0, '0, 1'b0, 1'b0);
      issue(32'h0, '0, '0, 1'b0, 1'b0);
      run_div(6'd7, 6'd2, '0, '0, "R2", h);
      chk(h === 1'b0, "R9 read three slots before", X'(h), '0);
      chk(hazard === 1'b0, "R9 flag low at completion", X'(hazard), '0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule